// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a slow time-base strobe (one pulse per 32768 Hz period) into a periodic flag pulse. A 4-bit rate code selects how many time-base ticks make up one interval. The generator runs only when three conditions hold: the periodic enable bit is set, the rate code is nonzero, and the clock dividers are not held in reset. Each time an interval completes, the block emits a one-cycle pulse. The interrupt flag logic next to it uses that pulse to set its periodic flag and to raise the interrupt.

When software reprograms the rate while the generator is running, the block keeps its phase. The ticks already counted since the last expiry count toward the new interval, up to one full new interval, so the next pulse comes that many ticks early. Any other condition that turns the generator off cancels the interval in progress. The next start then begins from zero.

Top module: `rate_gen`

## Requirements
- R1: After reset `flagPulse` is low, and the first interval begins from zero elapsed ticks.
- R2: Rate code 1 gives an interval of 128 time-base ticks, and rate code 2 gives 64.
- R3: Rate codes 3 to 15 give an interval of 2^(code−1) ticks. Code 15 gives 16384.
- R4: `flagPulse` is high for exactly one clock cycle, the cycle after the clock edge that sampled the completing `baseTick`. Intervals then repeat with the same length.
- R5: Only clock cycles with `baseTick` high advance the interval. No pulse follows a cycle in which `baseTick` is low.
- R6: Rate code 0 stops the generator. No pulses occur and the elapsed count is discarded.
- R7: While `intEnable` is low, no pulses occur. When it is raised again, a full interval follows.
- R8: While `dividerHold` is high (the dividers are in reset), no pulses occur. After release, a full interval follows.
- R9: Changing the rate code while running keeps the elapsed tick count. The next pulse follows after (new interval − elapsed) ticks.
- R10: If the elapsed count already reaches or exceeds the new interval, the pulse follows the next `baseTick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rateCode | input | 4 | Interval select code (0 = off) |
| intEnable | input | 1 | Periodic interrupt enable |
| dividerHold | input | 1 | High while the time-base dividers are held in reset |
| baseTick | input | 1 | One-cycle strobe per 32768 Hz time-base period |
| flagPulse | output | 1 | One-cycle pulse on each interval expiry |

## Verification
The block's only state is its elapsed-tick count. If that count is wrong, the next pulse moves earlier or later by exactly the size of the error, and this shows within one interval of the fault. The longest case is 16384 ticks, at the slowest code. If a disable, hold or code-0 condition leaves a stale count behind, the first interval after restart comes out short. Rate changes in both directions check the carried phase against the exact tick of the next pulse. An error in the period decode shows as a wrong interval length on every expiry.

// File: rtl/rate_gen_pkg.sv
package rate_gen_pkg;
  // shift used by the two fast codes: code c in {1,2} gives 1 << (FAST_SHIFT - c)
  localparam int FAST_SHIFT = 8;
  // highest code that uses the fast table
  localparam int FAST_LAST = 2;

  typedef struct packed {
    logic clr;    // generator idle: discard elapsed count
    logic inc;    // count one more tick
    logic wrap;   // interval complete: restart from zero
    logic clamp;  // count exceeds a newly shortened interval
  } rateStrobe_t;
endpackage

// File: rtl/rate_period_decode.sv
module rate_period_decode #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic [CODE_W-1:0] rateCode,
  output logic [CNT_W-1:0]  period
);
  import rate_gen_pkg::*;

  always_comb begin
    period = '0;
    if (rateCode == '0) begin
      period = '0;
    end else if (int'(rateCode) <= FAST_LAST) begin
      period = CNT_W'(1) << (FAST_SHIFT - int'(rateCode));
    end else begin
      period = CNT_W'(1) << (int'(rateCode) - 1);
    end
  end

  always_comb begin
    // R3
    period_onehot_chk: assert ($onehot0(period));
    // R6
    zero_code_chk: assert ((rateCode == '0) == (period == '0));
  end
endmodule

// File: rtl/rate_ctrl.sv
module rate_ctrl #(
  parameter int CODE_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CODE_W-1:0]         rateCode,
  input  logic                      intEnable,
  input  logic                      dividerHold,
  input  logic                      baseTick,
  input  logic                      atLimit,
  input  logic                      overLimit,
  output rate_gen_pkg::rateStrobe_t strobe,
  output logic                      flagPulse
);
  import rate_gen_pkg::*;

  logic active;

  always_comb begin
    active       = intEnable && !dividerHold && (rateCode != '0);
    strobe       = '0;
    strobe.clr   = !active;
    strobe.wrap  = active && baseTick && atLimit;
    strobe.inc   = active && baseTick && !atLimit;
    strobe.clamp = active && !baseTick && overLimit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagPulse <= 1'b0;
    end else begin
      flagPulse <= strobe.wrap;
    end
  end

  // R4
  flag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flagPulse |=> !flagPulse);

  // R5
  flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !baseTick |=> !flagPulse);

  // R7
  flag_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !intEnable |=> !flagPulse);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dividerHold |=> !flagPulse);
endmodule

// File: rtl/rate_datapath.sv
module rate_datapath #(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W-1:0]          period,
  input  rate_gen_pkg::rateStrobe_t strobe,
  output logic                      atLimit,
  output logic                      overLimit
);
  import rate_gen_pkg::*;

  logic [CNT_W-1:0] elapsed;
  logic [CNT_W:0]   nextCount;

  always_comb begin
    nextCount = {1'b0, elapsed} + 1'b1;
    atLimit   = nextCount >= {1'b0, period};
    overLimit = elapsed > period;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed <= '0;
    end else if (strobe.clr || strobe.wrap) begin
      elapsed <= '0;
    end else if (strobe.inc) begin
      elapsed <= nextCount[CNT_W-1:0];
    end else if (strobe.clamp) begin
      elapsed <= period;
    end
  end

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clr |=> elapsed == '0);

  // R4
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrap |=> elapsed == '0);

  // R10
  bounded_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.clr && !$past(strobe.clr) && period == $past(period)) |-> elapsed <= period);

  // R9
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.clr, strobe.inc, strobe.wrap, strobe.clamp}));
endmodule

// File: rtl/rate_gen.sv
module rate_gen #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              intEnable,
  input  logic              dividerHold,
  input  logic              baseTick,
  output logic              flagPulse
);
  import rate_gen_pkg::*;

  logic [CNT_W-1:0] period;
  logic             atLimit;
  logic             overLimit;
  rateStrobe_t      strobe;

  rate_period_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) uDecode (
    .rateCode (rateCode),
    .period   (period)
  );

  rate_ctrl #(.CODE_W(CODE_W)) uCtrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rateCode    (rateCode),
    .intEnable   (intEnable),
    .dividerHold (dividerHold),
    .baseTick    (baseTick),
    .atLimit     (atLimit),
    .overLimit   (overLimit),
    .strobe      (strobe),
    .flagPulse   (flagPulse)
  );

  rate_datapath #(.CNT_W(CNT_W)) uPath (
    .clk       (clk),
    .rst_n     (rst_n),
    .period    (period),
    .strobe    (strobe),
    .atLimit   (atLimit),
    .overLimit (overLimit)
  );
endmodule

// File: tb/rate_gen_test.sv
`timescale 1ns/1ps
module rate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] rateCode;
  logic       intEnable;
  logic       dividerHold;
  logic       baseTick;
  logic       flagPulse;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rate_gen uut (
    .clk(clk), .rst_n(rst_n), .rateCode(rateCode), .intEnable(intEnable),
    .dividerHold(dividerHold), .baseTick(baseTick), .flagPulse(flagPulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doTick(output bit fired);
    baseTick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    baseTick = 1'b0;
    fired = flagPulse;
  endtask

  task automatic idle(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (flagPulse) seen++;
    end
  endtask

  task automatic ticks(input int n, output int seen);
    bit f;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      doTick(f);
      if (f) seen++;
    end
  endtask

  task automatic untilFire(input int maxN, output int n);
    bit f;
    n = -1;
    for (int i = 1; i <= maxN; i++) begin
      doTick(f);
      if (f) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic stopGen();
    int s;
    intEnable = 1'b0;
    rateCode  = 4'd0;
    idle(1, s);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finishRun();
    end
  end

  initial begin
    int n, s, expP;
    rst_n = 1'b0; rateCode = 4'd0; intEnable = 1'b0; dividerHold = 1'b0; baseTick = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(flagPulse == 1'b0, "R1", flagPulse, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 first interval after reset is full
    rateCode = 4'd4; intEnable = 1'b1;
    untilFire(20, n);
    check(n == 8, "R1", n, 8);

    // R2 / R3 / R4 sweep of every code
    for (int c = 1; c <= 15; c++) begin
      stopGen();
      expP = (c <= 2) ? (1 << (8 - c)) : (1 << (c - 1));
      rateCode = 4'(c); intEnable = 1'b1;
      untilFire(expP + 2, n);
      check(n == expP, (c <= 2) ? "R2" : "R3", n, expP);
      idle(1, s);
      check(s == 0, "R4 single-cycle pulse", s, 0);
      untilFire(expP + 2, n);
      check(n == expP, "R4 repeat interval", n, expP);
    end

    // R5 idle cycles do not advance the interval
    stopGen();
    rateCode = 4'd5; intEnable = 1'b1;
    ticks(10, s);
    idle(100, s);
    check(s == 0, "R5 no pulse without tick", s, 0);
    untilFire(40, n);
    check(n == 6, "R5", n, 6);

    // R6 code 0 stops and discards elapsed count
    stopGen();
    rateCode = 4'd6; intEnable = 1'b1;
    ticks(20, s);
    rateCode = 4'd0;
    ticks(80, s);
    check(s == 0, "R6 no pulse at code 0", s, 0);
    rateCode = 4'd6;
    untilFire(80, n);
    check(n == 32, "R6", n, 32);

    // R7 enable low stops and cancels
    ticks(20, s);
    intEnable = 1'b0;
    ticks(60, s);
    check(s == 0, "R7 no pulse while disabled", s, 0);
    intEnable = 1'b1;
    untilFire(80, n);
    check(n == 32, "R7", n, 32);

    // R8 divider hold stops and cancels
    ticks(25, s);
    dividerHold = 1'b1;
    ticks(60, s);
    check(s == 0, "R8 no pulse in hold", s, 0);
    dividerHold = 1'b0;
    untilFire(80, n);
    check(n == 32, "R8", n, 32);

    // R9 shorten: 50 elapsed of 128, new interval 64 -> 14 ticks
    stopGen();
    rateCode = 4'd8; intEnable = 1'b1;
    ticks(50, s);
    check(s == 0, "R9 no early pulse", s, 0);
    rateCode = 4'd7;
    untilFire(100, n);
    check(n == 14, "R9 shorten", n, 14);

    // R9 lengthen: 10 elapsed of 16, new interval 128 -> 118 ticks
    stopGen();
    rateCode = 4'd5; intEnable = 1'b1;
    ticks(10, s);
    rateCode = 4'd8;
    untilFire(200, n);
    check(n == 118, "R9 lengthen", n, 118);

    // R10 elapsed beyond new interval: pulse on next tick
    stopGen();
    rateCode = 4'd8; intEnable = 1'b1;
    ticks(100, s);
    rateCode = 4'd5;
    idle(3, s);
    check(s == 0, "R10 no pulse without tick", s, 0);
    untilFire(20, n);
    check(n == 1, "R10", n, 1);
    untilFire(40, n);
    check(n == 16, "R10 following interval", n, 16);

    done = 1;
    finishRun();
  end
endmodule